// File: doc/BRIEF.md
# Ticket Lock Engine

This block arbitrates ownership of a small set of hardware locks among several requesters, handing out tickets in arrival order. Each lock keeps a pair of counters: the next ticket to hand out and the ticket currently being served. When a requester arrives it is issued the current next-ticket value, and that counter advances in the same cycle. This single atomic read-modify-write happens at arrival, not when the lock becomes free. The requester owns the lock from the moment the serving counter equals its ticket. When it releases, the serving counter moves on by one and the next waiter in line becomes the owner.

Each requester has a valid/ready acquire channel that carries a lock index. A requester holds at most one ticket at a time, so its ready stays low while it has one. Ready may depend on valid: when several idle requesters raise valid in the same cycle, only the lowest-numbered one sees ready. The others must keep valid and their lock index steady until accepted. Once accepted, the requester's ticket, its ownership flag and its distance from the head of the line are shown as plain outputs. The distance can be used as a backoff hint. Release is a one-cycle pulse with no handshake. The release applies to the lock the requester's ticket belongs to.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset every counter of every lock is zero and no requester holds a ticket, so the first requester accepted on any lock owns it in the cycle after acceptance.
- R2: An acquire is accepted on a clock edge where acq_valid and acq_ready are both high for that requester. acq_ready is high only for the lowest-numbered requester that has valid high and holds no ticket. At most one acquire is accepted per cycle. The lock index must be below the number of locks.
- R3: An accepted acquire stores the lock's next-ticket value as the requester's ticket, and the next-ticket value advances by one. Every acceptance on a lock therefore gets a distinct ticket.
- R4: A requester's own output is high exactly when it holds a ticket equal to its lock's serving value. At most one requester owns a given lock, and an owner keeps ownership until it releases.
- R5: Ownership of a lock passes in the order in which tickets were issued, regardless of requester numbering.
- R6: A release pulse from the owner advances that lock's serving value by one and clears the requester's ticket (busy low) in the next cycle.
- R7: A release pulse from a requester that is not the owner of a lock changes no counter and no ticket. rel_err for that requester is high for exactly the following cycle.
- R8: gap presents (ticket − serving) modulo 2^W while busy: zero for the owner, nonzero for a waiter. It is zero when the requester holds no ticket.
- R9: Both counters wrap modulo 2^W. Ticket and serving values are compared modulo 2^W, and the number of requesters must not exceed 2^W.
- R10: Locks are independent. Activity on one lock never changes the tickets, ownership or gaps of requesters on another lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | N | Per-requester acquire request |
| acq_lock | input | N*LW | Per-requester lock index, LW bits each |
| acq_ready | output | N | Per-requester acquire acceptance |
| rel | input | N | Per-requester release pulse |
| busy | output | N | Requester holds a ticket |
| own | output | N | Requester owns its lock |
| tkt | output | N*W | Held ticket per requester |
| gap | output | N*W | Distance from head of line per requester |
| rel_err | output | N | Release from a non-owner, one cycle late |

## Verification
The bench goes after simultaneous acquires, where a faulty arbiter would hand two requesters the same ticket or accept a busy one. It also exercises arrival order that runs against requester numbering, where a design that grants by index instead of by ticket would break first-come order. It sends stray releases from waiters and idle requesters, which a careless design would let advance the serving counter and so skip a waiter. Long runs push both counters past 2^W, where a comparison that ignores the modulus would stall the line or produce a wrong gap.

// File: rtl/tl_pkg.sv
package tl_pkg;
  // Width needed to index n items; never below one bit.
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tl_prio_arb.sv
module tl_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req[i];
    assign gnt[i]    = req[i] & ~seen[i];
  end
endmodule

// File: rtl/tl_counter_bank.sv
module tl_counter_bank #(
  parameter int L = 2,
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [L-1:0]   take,
  input  logic [L-1:0]   adv,
  output logic [L*W-1:0] next_flat,
  output logic [L*W-1:0] serve_flat
);
  for (genvar l = 0; l < L; l++) begin : g_lock
    logic [W-1:0] next_q, serve_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        next_q  <= '0;
        serve_q <= '0;
      end else begin
        if (take[l]) next_q  <= next_q + 1'b1;
        if (adv[l])  serve_q <= serve_q + 1'b1;
      end
    end
    assign next_flat[l*W +: W]  = next_q;
    assign serve_flat[l*W +: W] = serve_q;
  end
endmodule

// File: rtl/tl_slot.sv
module tl_slot #(
  parameter int W  = 4,
  parameter int LW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_lock,
  input  logic [W-1:0]  load_tkt,
  input  logic          clear,
  input  logic [W-1:0]  serve_now,
  output logic          busy,
  output logic [LW-1:0] lock_q,
  output logic [W-1:0]  tkt_q,
  output logic          own,
  output logic [W-1:0]  gap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      lock_q <= '0;
      tkt_q  <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      lock_q <= load_lock;
      tkt_q  <= load_tkt;
    end else if (clear) begin
      busy   <= 1'b0;
    end
  end

  assign own = busy && (tkt_q == serve_now);
  assign gap = busy ? (tkt_q - serve_now) : '0;
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
  import tl_pkg::*;
#(
  parameter int N  = 4,
  parameter int L  = 2,
  parameter int W  = 4,
  localparam int LW = sel_width(L)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   acq_valid,
  input  logic [N*LW-1:0] acq_lock,
  output logic [N-1:0]   acq_ready,
  input  logic [N-1:0]   rel,
  output logic [N-1:0]   busy,
  output logic [N-1:0]   own,
  output logic [N*W-1:0] tkt,
  output logic [N*W-1:0] gap,
  output logic [N-1:0]   rel_err
);
  logic [L*W-1:0]  next_flat, serve_flat;
  logic [L-1:0]    take, adv;
  logic [N-1:0]    rel_ok;
  logic [N*LW-1:0] slot_lock_flat;

  tl_prio_arb #(.N(N)) u_arb (
    .req (acq_valid & ~busy),
    .gnt (acq_ready)
  );

  tl_counter_bank #(.L(L), .W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .adv        (adv),
    .next_flat  (next_flat),
    .serve_flat (serve_flat)
  );

  for (genvar i = 0; i < N; i++) begin : g_req
    logic [LW-1:0] req_lock, held_lock;
    logic [W-1:0]  serve_sel, next_sel;
    assign req_lock  = acq_lock[i*LW +: LW];
    assign next_sel  = next_flat[req_lock*W +: W];
    assign serve_sel = serve_flat[held_lock*W +: W];
    assign rel_ok[i] = rel[i] & own[i];

    tl_slot #(.W(W), .LW(LW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acq_ready[i]),
      .load_lock (req_lock),
      .load_tkt  (next_sel),
      .clear     (rel_ok[i]),
      .serve_now (serve_sel),
      .busy      (busy[i]),
      .lock_q    (held_lock),
      .tkt_q     (tkt[i*W +: W]),
      .own       (own[i]),
      .gap       (gap[i*W +: W])
    );
    assign slot_lock_flat[i*LW +: LW] = held_lock;
  end

  always_comb begin
    take = '0;
    adv  = '0;
    for (int l = 0; l < L; l++) begin
      for (int i = 0; i < N; i++) begin
        if (acq_ready[i] && acq_lock[i*LW +: LW] == LW'(l)) take[l] = 1'b1;
        if (rel_ok[i] && slot_lock_flat[i*LW +: LW] == LW'(l)) adv[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rel_err <= '0;
    else        rel_err <= rel & ~own;
  end
endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
  parameter int N  = 4,
  parameter int L  = 2,
  parameter int W  = 4,
  parameter int LW = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    acq_valid,
  input logic [N-1:0]    acq_ready,
  input logic [N-1:0]    rel,
  input logic [N-1:0]    busy,
  input logic [N-1:0]    own,
  input logic [N*W-1:0]  gap,
  input logic [N-1:0]    rel_err,
  input logic [N*LW-1:0] slot_lock_flat
);
  p_single_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acq_valid & acq_ready));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_ready & busy) == '0);

  for (genvar l = 0; l < L; l++) begin : g_lk
    logic [N-1:0] on_lock;
    always_comb
      for (int i = 0; i < N; i++)
        on_lock[i] = own[i] && slot_lock_flat[i*LW +: LW] == LW'(l);
    p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(on_lock));
  end

  for (genvar i = 0; i < N; i++) begin : g_rq
    p_owner_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      own[i] && !rel[i] |=> own[i]);
    p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      own[i] && rel[i] |=> !busy[i]);
    p_bad_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rel[i] && !own[i] |=> rel_err[i]);
    p_gap_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] |-> ((gap[i*W +: W] == '0) == own[i]));
  end
endmodule

bind ticket_lock_unit tl_checker #(.N(N), .L(L), .W(W), .LW(LW)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acq_valid      (acq_valid),
  .acq_ready      (acq_ready),
  .rel            (rel),
  .busy           (busy),
  .own            (own),
  .gap            (gap),
  .rel_err        (rel_err),
  .slot_lock_flat (slot_lock_flat)
);

// File: tb/test_ticket_lock_unit.sv
`timescale 1ns/1ps
module test_ticket_lock_unit;
  localparam int N  = 4;
  localparam int L  = 2;
  localparam int W  = 4;
  localparam int LW = tl_pkg::sel_width(L);
  localparam int M  = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    acq_valid = '0;
  logic [N*LW-1:0] acq_lock = '0;
  logic [N-1:0]    acq_ready;
  logic [N-1:0]    rel = '0;
  logic [N-1:0]    busy, own, rel_err;
  logic [N*W-1:0]  tkt, gap;

  always #2.5 clk = ~clk;

  ticket_lock_unit #(.N(N), .L(L), .W(W)) i_ticket_lock_unit (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_lock(acq_lock),
    .acq_ready(acq_ready), .rel(rel), .busy(busy), .own(own),
    .tkt(tkt), .gap(gap), .rel_err(rel_err)
  );

  int compared = 0;
  int mismatched = 0;

  // Behavioural reference state
  int m_next[L], m_serve[L];
  int m_tkt[N], m_lock[N];
  bit m_busy[N], m_err[N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_owns(input int i);
    return m_busy[i] && m_serve[m_lock[i]] == m_tkt[i];
  endfunction

  function automatic int m_first_ready(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i] && !m_busy[i]) return i;
    return -1;
  endfunction

  task automatic compare_state();
    for (int i = 0; i < N; i++) begin
      int eg;
      eg = m_busy[i] ? ((m_tkt[i] - m_serve[m_lock[i]] + M) % M) : 0;
      chk(busy[i] == m_busy[i], "R6", $sformatf("busy[%0d]", i), busy[i], m_busy[i]);
      chk(own[i] == m_owns(i), "R4", $sformatf("own[%0d]", i), own[i], m_owns(i));
      if (m_busy[i])
        chk(int'(tkt[i*W +: W]) == m_tkt[i], "R3", $sformatf("tkt[%0d]", i),
            tkt[i*W +: W], m_tkt[i]);
      chk(int'(gap[i*W +: W]) == eg, "R8", $sformatf("gap[%0d]", i), gap[i*W +: W], eg);
      chk(rel_err[i] == m_err[i], "R7", $sformatf("rel_err[%0d]", i), rel_err[i], m_err[i]);
    end
  endtask

  // One cycle: drive at negedge, check ready, update model at the edge, check after.
  task automatic cycle(input logic [N-1:0] v, input logic [N*LW-1:0] lk,
                       input logic [N-1:0] r);
    int w;
    bit ok[N];
    acq_valid = v;
    acq_lock  = lk;
    rel       = r;
    #1;
    w = m_first_ready(v);
    for (int i = 0; i < N; i++)
      chk(acq_ready[i] == (i == w), "R2", $sformatf("acq_ready[%0d]", i),
          acq_ready[i], i == w);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      ok[i] = r[i] && m_owns(i);
      m_err[i] = r[i] && !ok[i];
    end
    for (int i = 0; i < N; i++)
      if (ok[i]) begin
        m_serve[m_lock[i]] = (m_serve[m_lock[i]] + 1) % M;
        m_busy[i] = 1'b0;
      end
    if (w >= 0) begin
      int lw;
      lw = int'(lk[w*LW +: LW]);
      m_tkt[w]  = m_next[lw];
      m_lock[w] = lw;
      m_busy[w] = 1'b1;
      m_next[lw] = (m_next[lw] + 1) % M;
    end
    @(negedge clk);
    acq_valid = '0;
    rel = '0;
    compare_state();
  endtask

  function automatic logic [N*LW-1:0] locks(input int a, b, c, d);
    logic [N*LW-1:0] x;
    x = '0;
    x[0*LW +: LW] = LW'(a);
    x[1*LW +: LW] = LW'(b);
    x[2*LW +: LW] = LW'(c);
    x[3*LW +: LW] = LW'(d);
    return x;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int l = 0; l < L; l++) begin m_next[l] = 0; m_serve[l] = 0; end
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_err[i] = 0; m_tkt[i] = 0; m_lock[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then first acquirer owns right away
    chk(busy == '0, "R1", "busy after reset", busy, 0);
    chk(own == '0, "R1", "own after reset", own, 0);
    cycle(4'b0100, locks(0, 0, 0, 0), '0);
    chk(own[2] == 1'b1 && tkt[2*W +: W] == '0, "R1", "first acquirer owns", own[2], 1);

    // R5: arrivals 3, then 1, then 0 on lock 0 behind requester 2
    cycle(4'b1000, locks(0, 0, 0, 0), '0);
    cycle(4'b0010, locks(0, 0, 0, 0), '0);
    cycle(4'b0001, locks(0, 0, 0, 0), '0);
    chk(gap[3*W +: W] == W'(1) && gap[0*W +: W] == W'(3), "R8", "waiter gaps",
        gap[0*W +: W], 3);

    // R7: waiter 0 releases without owning; counters untouched
    cycle('0, locks(0, 0, 0, 0), 4'b0001);
    chk(rel_err[0] == 1'b1 && own[2] == 1'b1, "R7", "stray release ignored", own[2], 1);

    // R5: order follows tickets: 2 -> 3 -> 1 -> 0
    cycle('0, locks(0, 0, 0, 0), 4'b0100);
    chk(own == 4'b1000, "R5", "owner after first release", own, 4'b1000);
    cycle('0, locks(0, 0, 0, 0), 4'b1000);
    chk(own == 4'b0010, "R5", "owner after second release", own, 4'b0010);

    // R10: lock 1 is free while lock 0 is held
    cycle(4'b0100, locks(0, 0, 1, 0), '0);
    chk(own[2] == 1'b1 && gap[0*W +: W] == W'(1), "R10", "lock1 independent", own[2], 1);
    cycle('0, locks(0, 0, 0, 0), 4'b0110);
    cycle('0, locks(0, 0, 0, 0), 4'b0001);

    // R9: wrap lock 1 counters with repeated acquire/release by requester 3
    for (int k = 0; k < 2 * M + 3; k++) begin
      int exp_t;
      exp_t = (k + 1) % M;
      cycle(4'b1000, locks(0, 0, 0, 1), '0);
      chk(int'(tkt[3*W +: W]) == exp_t && own[3], "R9", "wrapped ticket",
          tkt[3*W +: W], exp_t);
      cycle('0, locks(0, 0, 0, 0), 4'b1000);
    end

    // Mixed traffic against the reference model
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] v, r;
      v = N'($urandom);
      r = '0;
      for (int i = 0; i < N; i++) begin
        if (m_owns(i) && ($urandom % 3 == 0)) r[i] = 1'b1;
        else if ($urandom % 16 == 0) r[i] = 1'b1;
      end
      cycle(v, (N*LW)'($urandom), r);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule